// File: doc/BRIEF.md
# Stepped Digital AGC Controller

This block closes the gain loop of a receive path in the digital domain. It takes the signed samples that come out of the decimation filters after the A/D converter and sums their magnitudes over one chip period to get a level figure. It then checks that figure against a dead-band window held in two threshold inputs, and moves a 3-bit code for an external gain stage by one step. Each code step is worth 6 dB, so the eight codes span 0 to 42 dB.

The loop runs on a two-phase schedule tied to the chip strobe. The period that ends on one strobe is a measurement period: its level is judged and the step it calls for is stored. The next strobe applies that step to the gain code and starts a fresh measurement. The thresholds are sums over one chip period, so software scales them by the number of samples per chip. Deasserting the enable parks the gain at its highest code and restarts the schedule.

Top module: `agc_stepper`

## Requirements
- R1: After synchronous reset, `gain_code` is 7 (the highest gain) and `level_ok` is 0. The schedule starts in the measurement phase.
- R2: While `en` is low, `gain_code` is 7 from the next clock on, `level_ok` is 0, and chip strobes and samples have no effect. Raising `en` restarts in the measurement phase.
- R3: The level is the sum of the magnitudes of all valid samples between two chip strobes. A valid sample presented in the same cycle as a chip strobe counts toward the period that this strobe opens.
- R4: The phases alternate on each chip strobe. A strobe that closes a measurement period judges the level and leaves `gain_code` unchanged. The following strobe applies the stored step.
- R5: A level strictly greater than `thr_hi` lowers the gain code by one. A level equal to `thr_hi` counts as inside the window.
- R6: A level strictly smaller than `thr_lo` raises the gain code by one. A level equal to `thr_lo` counts as inside the window.
- R7: `level_ok` is set at the strobe that closes a measurement when the level is inside the window, and cleared there when it is outside. It keeps that value until the next measurement closes.
- R8: The gain code saturates at 0 and at 7 and never wraps.
- R9: The most negative sample code (-2048 for 12-bit samples) adds a magnitude of 2048.
- R10: If the thresholds are misordered and the level is both above `thr_hi` and below `thr_lo`, the gain is lowered.
- R11: Samples with `smp_valid` low do not contribute to the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Loop enable; low parks the gain at code 7 |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SMP_W | Signed two's-complement sample |
| chip_stb | input | 1 | One-cycle pulse at each chip boundary |
| thr_lo | input | ACC_W | Lower window bound on the per-chip magnitude sum |
| thr_hi | input | ACC_W | Upper window bound on the per-chip magnitude sum |
| gain_code | output | GAIN_W | Code for the analog gain stage, 6 dB per step |
| level_ok | output | 1 | Last judged level was inside the window |

## Verification
Two events can land on the same clock: the chip strobe that clears the accumulator and a valid sample that must be summed. The bench places a sample on the strobe cycle at a measurement close, and again at an update strobe. It sets both thresholds equal to the expected sum, so `level_ok` rises only if the sample was moved into the new period rather than dropped or added to the old one. The update strobe also applies a gain step in the same cycle that the new measurement starts. For that case the bench checks that the code holds through the next measurement close and changes only at the strobe after it.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  typedef enum logic {
    PH_MEAS = 1'b0,
    PH_UPD  = 1'b1
  } phase_e;

  // Sum width that cannot overflow for max_spc samples of full magnitude.
  function automatic int acc_width(int smp_w, int max_spc);
    return smp_w + $clog2(max_spc + 1);
  endfunction

endpackage

// File: rtl/agc_level_acc.sv
module agc_level_acc
  import agc_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int ACC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    clear,
  output logic [ACC_W-1:0]        acc_o
);

  logic [SMP_W-1:0] mag;

  // Two's-complement magnitude; the most negative code maps to 2**(SMP_W-1).
  always_comb begin
    if (smp_data[SMP_W-1]) mag = ~smp_data + SMP_W'(1);
    else                   mag = smp_data;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc_o <= '0;
    end else if (clear) begin
      acc_o <= smp_valid ? ACC_W'(mag) : '0;
    end else if (smp_valid) begin
      acc_o <= acc_o + ACC_W'(mag);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (en && !clear && smp_valid) |=> (acc_o >= $past(acc_o))); // R3

  AST_IDLE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (en && !clear && !smp_valid) |=> $stable(acc_o)); // R11

endmodule

// File: rtl/agc_window_cmp.sv
module agc_window_cmp
  import agc_pkg::*;
#(
  parameter int ACC_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             meas_fire,
  input  logic [ACC_W-1:0] level,
  input  logic [ACC_W-1:0] thr_lo,
  input  logic [ACC_W-1:0] thr_hi,
  output step_e            step_o,
  output logic             ok_o
);

  logic  above, below;
  step_e step_nxt;

  always_comb begin
    above = level > thr_hi;
    below = level < thr_lo;
    // Too loud wins over too quiet when the bounds are misordered.
    if (above)      step_nxt = STEP_DN;
    else if (below) step_nxt = STEP_UP;
    else            step_nxt = STEP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      step_o <= STEP_HOLD;
      ok_o   <= 1'b0;
    end else if (meas_fire) begin
      step_o <= step_nxt;
      ok_o   <= !above && !below;
    end
  end

  AST_OK_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_o) |-> $past(meas_fire)); // R7

endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step
  import agc_pkg::*;
#(
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              upd_fire,
  input  step_e             step_i,
  output logic [GAIN_W-1:0] gain_o
);

  localparam logic [GAIN_W-1:0] GMAX  = '1;
  localparam logic [GAIN_W:0]   ONE_X = (GAIN_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gain_o <= GMAX;
    end else if (upd_fire) begin
      case (step_i)
        STEP_UP: if (gain_o != GMAX)      gain_o <= gain_o + GAIN_W'(1);
        STEP_DN: if (gain_o != '0)        gain_o <= gain_o - GAIN_W'(1);
        default: gain_o <= gain_o;
      endcase
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |->
      (({1'b0, gain_o} == {1'b0, $past(gain_o)}) ||
       ({1'b0, gain_o} == {1'b0, $past(gain_o)} + ONE_X) ||
       ({1'b0, $past(gain_o)} == {1'b0, gain_o} + ONE_X))); // R8

  AST_HOLD_OFF_UPD: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst) && !$past(upd_fire)) |-> (gain_o == $past(gain_o))); // R4

  AST_DISABLED_MAX: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gain_o == GMAX)); // R2

endmodule

// File: rtl/agc_stepper.sv
module agc_stepper
  import agc_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int MAX_SPC = 1024,
  parameter int GAIN_W  = 3,
  parameter int ACC_W   = agc_pkg::acc_width(SMP_W, MAX_SPC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    chip_stb,
  input  logic [ACC_W-1:0]        thr_lo,
  input  logic [ACC_W-1:0]        thr_hi,
  output logic [GAIN_W-1:0]       gain_code,
  output logic                    level_ok
);

  phase_e           phase_q;
  logic             meas_fire, upd_fire;
  logic [ACC_W-1:0] level;
  step_e            step_q;

  assign meas_fire = en && chip_stb && (phase_q == PH_MEAS);
  assign upd_fire  = en && chip_stb && (phase_q == PH_UPD);

  always_ff @(posedge clk) begin
    if (rst || !en)    phase_q <= PH_MEAS;
    else if (chip_stb) phase_q <= (phase_q == PH_MEAS) ? PH_UPD : PH_MEAS;
  end

  agc_level_acc #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .smp_valid(smp_valid),
    .smp_data(smp_data), .clear(chip_stb), .acc_o(level)
  );

  agc_window_cmp #(.ACC_W(ACC_W)) u_cmp (
    .clk(clk), .rst(rst), .en(en), .meas_fire(meas_fire), .level(level),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .step_o(step_q), .ok_o(level_ok)
  );

  agc_gain_step #(.GAIN_W(GAIN_W)) u_gain (
    .clk(clk), .rst(rst), .en(en), .upd_fire(upd_fire),
    .step_i(step_q), .gain_o(gain_code)
  );

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (rst)
    meas_fire |=> (phase_q == PH_UPD)); // R4

endmodule

// File: tb/agc_stepper_test.sv
module agc_stepper_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int AW = 23;
  localparam int NV = 15;

  typedef struct packed {
    logic signed [SW-1:0] v;
    logic [7:0]           n;
    logic [AW-1:0]        lo;
    logic [AW-1:0]        hi;
    logic                 ok;
    logic [2:0]           g;
  } vec_t;

  // sample value, count, lower, upper, expected ok, expected gain after update
  localparam vec_t TBL [NV] = '{
    '{12'sd100,    8'd10, 23'd900,  23'd1100, 1'b1, 3'd7},
    '{-12'sd100,   8'd10, 23'd1200, 23'd2000, 1'b0, 3'd7},
    '{12'sd500,    8'd8,  23'd1000, 23'd3000, 1'b0, 3'd6},
    '{12'sd500,    8'd8,  23'd1000, 23'd3000, 1'b0, 3'd5},
    '{-12'sd2048,  8'd2,  23'd4096, 23'd4096, 1'b1, 3'd5},
    '{12'sd2047,   8'd2,  23'd4095, 23'd5000, 1'b0, 3'd6},
    '{12'sd10,     8'd1,  23'd20,   23'd5,    1'b0, 3'd5},
    '{12'sd0,      8'd0,  23'd0,    23'd0,    1'b1, 3'd5},
    '{12'sd1000,   8'd20, 23'd100,  23'd200,  1'b0, 3'd4},
    '{12'sd1000,   8'd20, 23'd100,  23'd200,  1'b0, 3'd3},
    '{12'sd1000,   8'd20, 23'd100,  23'd200,  1'b0, 3'd2},
    '{12'sd1000,   8'd20, 23'd100,  23'd200,  1'b0, 3'd1},
    '{12'sd1000,   8'd20, 23'd100,  23'd200,  1'b0, 3'd0},
    '{12'sd1000,   8'd20, 23'd100,  23'd200,  1'b0, 3'd0},
    '{12'sd1,      8'd1,  23'd50,   23'd60,   1'b0, 3'd1}
  };

  logic clk = 1'b0, rst = 1'b1, en = 1'b1, sv = 1'b0, cs = 1'b0;
  logic signed [SW-1:0] sd = '0;
  logic [AW-1:0] lo = '0, hi = '0;
  logic [2:0] gain;
  logic ok;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_stepper uut (
    .clk(clk), .rst(rst), .en(en), .smp_valid(sv), .smp_data(sd),
    .chip_stb(cs), .thr_lo(lo), .thr_hi(hi), .gain_code(gain), .level_ok(ok)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Valid samples interleaved with invalid junk cycles (R11).
  task automatic feed(logic signed [SW-1:0] v, int n);
    for (int i = 0; i < n; i++) begin
      sv = 1'b1; sd = v; cyc();
      sv = 1'b0; sd = 12'sh7FF; cyc();
    end
    sd = '0;
  endtask

  task automatic strobe();
    cs = 1'b1; cyc(); cs = 1'b0;
  endtask

  initial begin
    cyc(); cyc(); cyc();
    chk("R1 gain at reset", gain, 3'd7);
    chk("R1 ok at reset", ok, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [2:0] g_before;
      lo = TBL[k].lo; hi = TBL[k].hi;
      g_before = gain;
      feed(TBL[k].v, int'(TBL[k].n));
      strobe();
      chk($sformatf("R3 R7 R11 ok after measurement row %0d", k), ok, TBL[k].ok);
      chk($sformatf("R4 gain held at measurement close row %0d", k), gain, g_before);
      feed(12'sd300, 2);
      strobe();
      chk($sformatf("R5 R6 R8 R9 R10 gain after update row %0d", k), gain, TBL[k].g);
    end

    // R3: sample on a measurement-closing strobe belongs to the next period
    lo = 23'd500; hi = 23'd500;
    feed(12'sd100, 5);
    sv = 1'b1; sd = 12'sd300; cs = 1'b1; cyc(); cs = 1'b0; sv = 1'b0;
    chk("R3 strobe-cycle sample excluded at close", ok, 1'b1);
    // R3: sample on the update strobe opens the next measurement
    sv = 1'b1; sd = 12'sd300; cs = 1'b1; cyc(); cs = 1'b0; sv = 1'b0;
    chk("R4 gain inside window after update", gain, 3'd1);
    feed(12'sd100, 2);
    strobe();
    chk("R3 update-strobe sample included", ok, 1'b1);
    strobe();

    // R2: disable parks gain and ignores strobes
    en = 1'b0; cyc();
    chk("R2 gain parked when disabled", gain, 3'd7);
    chk("R2 ok cleared when disabled", ok, 1'b0);
    lo = 23'd0; hi = 23'd10;
    feed(12'sd1000, 5); strobe(); strobe();
    chk("R2 strobes ignored when disabled", gain, 3'd7);
    en = 1'b1;
    feed(12'sd1000, 5); strobe();
    chk("R4 first strobe after enable only measures", gain, 3'd7);
    chk("R7 ok low for loud level", ok, 1'b0);
    strobe();
    chk("R5 gain lowered after re-enable", gain, 3'd6);

    // R1: reset in mid-run
    rst = 1'b1; cyc();
    chk("R1 gain after mid-run reset", gain, 3'd7);
    chk("R1 ok after mid-run reset", ok, 1'b0);
    rst = 1'b0; cyc();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog R1-all: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule